// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words. Each word has a sign in bit 31, a biased exponent in bits 30..23 and a fraction in bits 22..0. A normal word stands for (-1)^s x (1.F) x 2^(E-127). The block works through a fixed three-stage pipeline. The first stage puts back the implicit leading one, orders the operands by magnitude and shifts the smaller significand right by the exponent difference. It keeps a guard bit, a round bit and a sticky bit below the significand. The second stage adds or subtracts the magnitudes and normalizes the result, either with one right shift or with as many left shifts as needed. The third stage rounds to nearest-even, normalizes again if rounding carried out to 2.0, clamps the exponent range and packs the result.

Any exponent field of 0 is read as zero. Denormal values, infinity or NaN operands and other rounding modes are not handled. A new operand pair may be presented on every cycle with `in_valid`. Its result appears with `out_valid` three cycles later, and results leave in the order the operands came in.

Top module: `fp32_addsub`

## Requirements
- R1: A pair accepted with `in_valid` high at a rising edge yields exactly one `out_valid` pulse with its result after the third rising edge that follows. Results keep input order. `out_valid` is low while `rst_n` is low.
- R2: Operands of equal effective sign add their magnitudes, and a sum of 2.0 or more is shifted right once with the exponent raised by one (0xBF400000 + 0xC0A00000 = 0xC0B80000).
- R3: Operands of opposite effective sign subtract the smaller magnitude from the larger. The result carries the sign of the larger and is shifted left until its leading one is in place, with the exponent lowered once per shift (0x3F000000 + 0xBEE00000 = 0x3D800000).
- R4: With `op_sub` = 1 the result is `op_a` minus `op_b`, which is the sum with the sign bit 31 of `op_b` inverted.
- R5: Rounding is to nearest. An exact halfway case rounds to the even significand (0x3F800000 + 0x33800000 = 0x3F800000; 0x3F800001 + 0x33800000 = 0x3F800002).
- R6: Bits shifted out below the round position are ORed into a sticky bit, so a value just above halfway rounds up (0x3F800000 + 0x33800080 = 0x3F800001).
- R7: When rounding carries the significand to 2.0, the result is shifted right once more and the exponent is raised (0x3FFFFFFF + 0x33800000 = 0x40000000).
- R8: A subtraction that cancels exactly returns +0 (0x00000000), whatever the operand signs.
- R9: A final exponent above 254 returns infinity with the result's sign: exponent field all ones and fraction zero (0x7F800000 or 0xFF800000).
- R10: A final exponent below 1 returns zero with the result's sign (0x00800000 - 0x00800001 = 0x80000000).
- R11: An operand whose exponent field (bits 30..23) is 0 is zero and skips the arithmetic. If `op_b` is zero, `op_a` is returned unchanged. Otherwise, if `op_a` is zero, `op_b` is returned with bit 31 XORed with `op_sub`.
- R12: Exponent differences wider than the extended significand leave only the sticky bit, so a tiny operand does not move a large one (0x3F800000 +/- 0x0D800000 = 0x3F800000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 selects op_a minus op_b, 0 selects the sum |
| out_valid | output | 1 | Result present this cycle |
| result | output | 32 | Rounded, packed result |

## Verification
The bench builds the block with the default widths, an 8-bit exponent and a 23-bit fraction. With these widths the worked hex cases above apply directly, and an exact 64-bit integer model in the bench covers every exponent difference that can still affect rounding. These widths also make reachable the halfway ties, the carry to 2.0 after rounding, overflow at exponent 254 and the flush near the smallest normal exponent. Directed pairs cover those corners. Several hundred random pairs, most with close exponents so that long left shifts occur, are streamed back to back to exercise the pipeline order.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  typedef enum logic {
    PATH_ARITH = 1'b0,
    PATH_PASS  = 1'b1
  } path_e;

  // nearest-even decision from kept lsb, guard, round and sticky
  function automatic logic rne_up(input logic lsb, input logic g,
                                  input logic r, input logic s);
    return g & (r | s | lsb);
  endfunction

endpackage

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int MAN_W = FRAC_W + 1,
  localparam int EXT_W = MAN_W + 3,
  localparam int SH_W  = $clog2(EXT_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act,
  input  logic [W-1:0]       op_a,
  input  logic [W-1:0]       op_b,
  input  logic               op_sub,
  output fpa_pkg::path_e     path,
  output logic [W-1:0]       pass_word,
  output logic               res_sign,
  output logic               eff_sub,
  output logic [EXP_W-1:0]   exp_big,
  output logic [EXT_W-1:0]   man_big,
  output logic [EXT_W-1:0]   man_sml
);
  import fpa_pkg::*;

  logic             sign_b;
  logic             a_zero, b_zero, a_ge;
  logic [EXP_W-1:0] exp_sml, diff;
  logic [SH_W-1:0]  shamt;
  logic [MAN_W-1:0] sig_big, sig_sml;
  logic [EXT_W-1:0] ext, shifted, mask;

  assign sign_b = op_b[W-1] ^ op_sub;
  assign a_zero = (op_a[W-2:FRAC_W] == '0);
  assign b_zero = (op_b[W-2:FRAC_W] == '0);
  assign a_ge   = (op_a[W-2:0] >= op_b[W-2:0]);

  always_comb begin
    if (b_zero) begin
      path      = PATH_PASS;
      pass_word = op_a;
    end else if (a_zero) begin
      path      = PATH_PASS;
      pass_word = {sign_b, op_b[W-2:0]};
    end else begin
      path      = PATH_ARITH;
      pass_word = '0;
    end
  end

  always_comb begin
    if (a_ge) begin
      res_sign = op_a[W-1];
      exp_big  = op_a[W-2:FRAC_W];
      exp_sml  = op_b[W-2:FRAC_W];
      sig_big  = {1'b1, op_a[FRAC_W-1:0]};
      sig_sml  = {1'b1, op_b[FRAC_W-1:0]};
    end else begin
      res_sign = sign_b;
      exp_big  = op_b[W-2:FRAC_W];
      exp_sml  = op_a[W-2:FRAC_W];
      sig_big  = {1'b1, op_b[FRAC_W-1:0]};
      sig_sml  = {1'b1, op_a[FRAC_W-1:0]};
    end
  end

  assign eff_sub = op_a[W-1] ^ sign_b;
  assign diff    = exp_big - exp_sml;
  assign shamt   = (diff >= EXP_W'(EXT_W)) ? SH_W'(EXT_W) : SH_W'(diff);
  assign ext     = {sig_sml, 3'b000};
  assign shifted = ext >> shamt;
  assign mask    = ~({EXT_W{1'b1}} << shamt);
  assign man_big = {sig_big, 3'b000};
  assign man_sml = {shifted[EXT_W-1:1], shifted[0] | (|(ext & mask))};

  // R3
  swap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && path == PATH_ARITH) |-> (man_big >= man_sml));

endmodule

// File: rtl/fpa_addnorm.sv
module fpa_addnorm #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MAN_W = FRAC_W + 1,
  localparam int EXT_W = MAN_W + 3,
  localparam int NE_W  = EXP_W + 2,
  localparam int LZ_W  = $clog2(EXT_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   act,
  input  logic                   eff_sub,
  input  logic [EXP_W-1:0]       exp_big,
  input  logic [EXT_W-1:0]       man_big,
  input  logic [EXT_W-1:0]       man_sml,
  output logic                   is_zero,
  output logic                   carry_ev,
  output logic [EXT_W-1:0]       norm_man,
  output logic signed [NE_W-1:0] norm_exp
);

  logic [EXT_W:0]   sum;
  logic [LZ_W-1:0]  lz;
  logic             found;
  logic signed [NE_W-1:0] exp_ext;

  assign sum      = eff_sub ? ({1'b0, man_big} - {1'b0, man_sml})
                            : ({1'b0, man_big} + {1'b0, man_sml});
  assign carry_ev = sum[EXT_W];
  assign is_zero  = (sum == '0);
  assign exp_ext  = $signed({2'b00, exp_big});

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found && sum[i]) begin
        lz    = LZ_W'(EXT_W - 1 - i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (carry_ev) begin
      norm_man = {sum[EXT_W:2], sum[1] | sum[0]};
      norm_exp = exp_ext + NE_W'(1);
    end else begin
      norm_man = sum[EXT_W-1:0] << lz;
      norm_exp = exp_ext - $signed({{(NE_W-LZ_W){1'b0}}, lz});
    end
  end

  // R2
  carry_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && carry_ev) |-> !eff_sub);

  // R3
  norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !is_zero) |-> norm_man[EXT_W-1]);

endmodule

// File: rtl/fpa_round.sv
module fpa_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int MAN_W = FRAC_W + 1,
  localparam int EXT_W = MAN_W + 3,
  localparam int NE_W  = EXP_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   act,
  input  logic                   sign,
  input  logic [EXT_W-1:0]       norm_man,
  input  logic signed [NE_W-1:0] norm_exp,
  output logic                   round_up,
  output logic                   renorm,
  output logic                   ovf,
  output logic                   unf,
  output logic [W-1:0]           word
);
  import fpa_pkg::*;

  localparam logic signed [NE_W-1:0] EXP_TOP = NE_W'((1 << EXP_W) - 2);

  logic [MAN_W-1:0]       kept;
  logic [MAN_W:0]         rounded;
  logic [FRAC_W-1:0]      frac;
  logic signed [NE_W-1:0] exp_r;

  assign kept     = norm_man[EXT_W-1:3];
  assign round_up = rne_up(kept[0], norm_man[2], norm_man[1], norm_man[0]);
  assign rounded  = {1'b0, kept} + {{MAN_W{1'b0}}, round_up};
  assign renorm   = rounded[MAN_W];
  assign frac     = renorm ? rounded[FRAC_W:1] : rounded[FRAC_W-1:0];
  assign exp_r    = norm_exp + $signed({{(NE_W-1){1'b0}}, renorm});
  assign ovf      = (exp_r > EXP_TOP);
  assign unf      = (exp_r < $signed(NE_W'(1)));

  always_comb begin
    if (ovf)      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (unf) word = {sign, {(W-1){1'b0}}};
    else          word = {sign, exp_r[EXP_W-1:0], frac};
  end

  // R7
  renorm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && renorm) |-> (round_up && kept == '1));

endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int MAN_W = FRAC_W + 1,
  localparam int EXT_W = MAN_W + 3,
  localparam int NE_W  = EXP_W + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         op_sub,
  output logic         out_valid,
  output logic [W-1:0] result
);
  import fpa_pkg::*;

  // stage 1 combinational outputs
  path_e            al_path;
  logic [W-1:0]     al_pass;
  logic             al_sign, al_sub;
  logic [EXP_W-1:0] al_exp;
  logic [EXT_W-1:0] al_big, al_sml;

  // stage 1 registers
  logic             s1_v;
  path_e            s1_path;
  logic [W-1:0]     s1_pass;
  logic             s1_sign, s1_sub;
  logic [EXP_W-1:0] s1_exp;
  logic [EXT_W-1:0] s1_big, s1_sml;

  // stage 2 combinational outputs
  logic                   an_zero, an_carry;
  logic [EXT_W-1:0]       an_man;
  logic signed [NE_W-1:0] an_exp;

  // stage 2 registers
  logic                   s2_v;
  path_e                  s2_path;
  logic [W-1:0]           s2_pass;
  logic                   s2_sign, s2_zero;
  logic [EXT_W-1:0]       s2_man;
  logic signed [NE_W-1:0] s2_exp;

  // stage 3 events
  logic         rd_up, rd_renorm, rd_ovf, rd_unf;
  logic [W-1:0] rd_word;
  logic [1:0]   warm;

  fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .clk(clk), .rst_n(rst_n), .act(in_valid),
    .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
    .path(al_path), .pass_word(al_pass), .res_sign(al_sign),
    .eff_sub(al_sub), .exp_big(al_exp), .man_big(al_big), .man_sml(al_sml));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_path <= al_path;
      s1_pass <= al_pass;
      s1_sign <= al_sign;
      s1_sub  <= al_sub;
      s1_exp  <= al_exp;
      s1_big  <= al_big;
      s1_sml  <= al_sml;
    end
  end

  fpa_addnorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addnorm (
    .clk(clk), .rst_n(rst_n), .act(s1_v && s1_path == PATH_ARITH),
    .eff_sub(s1_sub), .exp_big(s1_exp), .man_big(s1_big), .man_sml(s1_sml),
    .is_zero(an_zero), .carry_ev(an_carry), .norm_man(an_man),
    .norm_exp(an_exp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_v <= 1'b0;
    else        s2_v <= s1_v;
  end

  always_ff @(posedge clk) begin
    if (s1_v) begin
      s2_path <= s1_path;
      s2_pass <= s1_pass;
      s2_sign <= s1_sign;
      s2_zero <= an_zero;
      s2_man  <= an_man;
      s2_exp  <= an_exp;
    end
  end

  fpa_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .clk(clk), .rst_n(rst_n),
    .act(s2_v && s2_path == PATH_ARITH && !s2_zero),
    .sign(s2_sign), .norm_man(s2_man), .norm_exp(s2_exp),
    .round_up(rd_up), .renorm(rd_renorm), .ovf(rd_ovf), .unf(rd_unf),
    .word(rd_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s2_v;
  end

  always_ff @(posedge clk) begin
    if (s2_v) begin
      if (s2_path == PATH_PASS) result <= s2_pass;
      else if (s2_zero)         result <= '0;
      else                      result <= rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R8
  cancel_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && s2_path == PATH_ARITH && s2_zero) |=> (result == '0));

  // R9
  inf_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && s2_path == PATH_ARITH && !s2_zero && rd_ovf)
      |=> (result[W-2:FRAC_W] == '1 && result[FRAC_W-1:0] == '0));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && s2_path == PATH_ARITH && !s2_zero && rd_unf)
      |=> (result[W-2:0] == '0 && result[W-1] == $past(s2_sign)));

endmodule

// File: tb/test_fp32_addsub.sv
module test_fp32_addsub;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        op_sub = 1'b0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] val;
    int          cyc;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  fp32_addsub i_fp32_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
    .op_b(op_b), .op_sub(op_sub), .out_valid(out_valid), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // exact integer model: scale the larger operand up, sum, then round
  function automatic logic [31:0] model_sum(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic sub);
    logic sbn, neg;
    int ea, eb, emax, d, base, p, e, sh;
    longint unsigned ma, mb, m, keep, rem, half;
    longint s;
    sbn = b[31] ^ sub;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if (eb == 0) return a;
    if (ea == 0) return {sbn, b[30:0]};
    ma = {40'd0, 1'b1, a[22:0]};
    mb = {40'd0, 1'b1, b[22:0]};
    emax = (ea > eb) ? ea : eb;
    d = emax - ((ea < eb) ? ea : eb);
    if (d > 34) d = 34;
    base = emax - d;
    if (ea >= eb) ma = ma << d;
    else          mb = mb << d;
    s = (a[31] ? -longint'(ma) : longint'(ma)) + (sbn ? -longint'(mb) : longint'(mb));
    if (s == 0) return 32'h0000_0000;
    neg = (s < 0);
    m = neg ? longint'(-s) : longint'(s);
    p = 0;
    for (int i = 0; i < 64; i++) if (m[i]) p = i;
    e = base + p - 23;
    if (p > 23) begin
      sh = p - 23;
      keep = m >> sh;
      rem = m & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && keep[0])) keep = keep + 64'd1;
      if (keep == (64'd1 << 24)) begin
        keep = keep >> 1;
        e = e + 1;
      end
    end else begin
      keep = m << (23 - p);
    end
    if (e > 254) return {neg, 8'hFF, 23'd0};
    if (e < 1)   return {neg, 31'd0};
    return {neg, e[7:0], keep[22:0]};
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic sub, input logic [31:0] want,
                       input string tag);
    exp_t it;
    @(negedge clk);
    op_a = a;
    op_b = b;
    op_sub = sub;
    in_valid = 1'b1;
    it.val = want;
    it.cyc = cyc;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = $urandom;
      op_b = $urandom;
    end
  endtask

  task automatic drive_model(input logic [31:0] a, input logic [31:0] b,
                             input logic sub, input string tag);
    drive(a, b, sub, model_sum(a, b, sub), tag);
  endtask

  function automatic logic [31:0] rnd_word(input int ebase, input int spread);
    int e;
    e = ebase + int'($urandom_range(spread * 2)) - spread;
    if (e < 1) e = 1;
    if (e > 254) e = 254;
    return {1'($urandom), e[7:0], 23'($urandom)};
  endfunction

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R1 out_valid in reset: actual=%b expected=0", out_valid);
      end
    end else if (out_valid === 1'b1) begin
      if (sb_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R1 unexpected result: actual=%h expected=none", result);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        checks++;
        if (result !== it.val) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, result, it.val);
        end
        checks++;
        if (cyc - it.cyc != 3) begin
          errors++;
          $display("FAIL R1 latency (%s): actual=%0d expected=3", it.tag, cyc - it.cyc);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    drive(32'hBF400000, 32'hC0A00000, 1'b0, 32'hC0B80000, "R2 same-sign");
    drive(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, "R2 carry out");
    drive(32'h3F000000, 32'hBEE00000, 1'b0, 32'h3D800000, "R3 cancel");
    drive(32'hBEE00000, 32'h3F000000, 1'b0, 32'h3D800000, "R3 larger sign");
    drive(32'h3F000000, 32'h3EE00000, 1'b1, 32'h3D800000, "R4 sub");
    drive(32'h3F800000, 32'hC0000000, 1'b1, 32'h40400000, "R4 sub neg");
    drive(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, "R5 tie even down");
    drive(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, "R5 tie even up");
    drive(32'h3F800000, 32'h33800080, 1'b0, 32'h3F800001, "R6 sticky");
    drive(32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, "R7 renorm");
    drive(32'h3F800000, 32'hBF800000, 1'b0, 32'h00000000, "R8 zero");
    drive(32'hC1200000, 32'hC1200000, 1'b1, 32'h00000000, "R8 zero sub");
    drive(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, "R9 inf pos");
    drive(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, "R9 inf neg");
    drive(32'h00800000, 32'h00800001, 1'b1, 32'h80000000, "R10 flush neg");
    drive(32'h00800001, 32'h80800000, 1'b0, 32'h00000000, "R10 flush pos");
    drive(32'h00000000, 32'h40490FDB, 1'b0, 32'h40490FDB, "R11 a zero");
    drive(32'h00000000, 32'h40490FDB, 1'b1, 32'hC0490FDB, "R11 a zero sub");
    drive(32'hC0490FDB, 32'h80000000, 1'b1, 32'hC0490FDB, "R11 b zero");
    drive(32'h80000000, 32'h00000000, 1'b0, 32'h80000000, "R11 both zero");
    drive(32'h3F800000, 32'h0D800000, 1'b0, 32'h3F800000, "R12 wide add");
    drive(32'h3F800000, 32'h0D800000, 1'b1, 32'h3F800000, "R12 wide sub");
    idle(5);

    // random streams, back to back
    for (int n = 0; n < 400; n++) begin
      int eb;
      logic [31:0] a, b;
      eb = int'($urandom_range(250)) + 2;
      a = rnd_word(eb, 2);
      case ($urandom_range(9))
        0:       b = rnd_word(eb, 60);
        1:       b = {1'($urandom), 31'd0};
        2:       b = {1'($urandom), a[30:0]};
        default: b = rnd_word(eb, 1);
      endcase
      drive_model(a, b, 1'($urandom), "R3/R5 random");
    end
    idle(3);
    for (int n = 0; n < 60; n++) begin
      drive_model(rnd_word(253, 1), rnd_word(253, 1), 1'($urandom), "R9 random");
      drive_model(rnd_word(2, 1), rnd_word(2, 1), 1'($urandom), "R10 random");
    end
    idle(8);

    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results: actual=%0d expected=0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule